// File: doc/BRIEF.md
# Page-Buffered EEPROM Write Engine

This block is the device-side write path of a byte-wide nonvolatile memory, built as synchronous logic. A host drives a parallel bus: a 15-bit address, 8-bit write data, and active-low chip-select, output-enable and write-enable lines. A write strobe exists only while chip-select and write-enable are both low and output-enable is high. The strobe must last long enough to pass a glitch filter. Each accepted strobe deposits one byte into a 64-byte page latch. The upper address bits name the page and the lower six bits pick the byte within it.

A load window counter restarts with every accepted byte. When the window runs out, the engine stops taking bytes and starts a programming interval of fixed length. At the end of that interval, only the bytes that were actually loaded are copied into a behavioural memory array. While programming is under way, a read returns a status byte instead of array data. All bus strobes are ignored during that time, and also during a settling interval after reset or after a power-up indication.

All time limits are clock-cycle counts set by parameters. The array holds `ARR_PAGES` pages, and the page number is folded onto the array by taking its low bits.

Top module: `pgwr_eeprom`

## Requirements
- R1: Reset behaviour. While reset is asserted, and after it is released, `bus_dout`, `busy_o` and `page_err_o` are all 0.
- R2: Normal read. A read is open when `cs_n`=0, `oe_n`=0 and `we_n`=1. One clock after a read is open and no programming is running, `bus_dout` shows the array byte addressed by `bus_addr`. The array location is given by the low `log2(ARR_PAGES)` page bits followed by bits 5..0. One clock after no read is open, `bus_dout` is 0.
- R3: Strobe capture. The address is the value present in the first cycle of the write strobe. The data is the value present in the last cycle of the strobe.
- R4: Page loading. Bits 14..6 of the address name the page and bits 5..0 name the byte. Bytes may be loaded in any order, and a later load to the same offset replaces the earlier one. At commit, only loaded offsets change in the array.
- R5: Load window. If no further byte is accepted within `BLC_CYC` cycles of the last accepted byte, programming starts. Strobes seen while programming is running are ignored.
- R6: Programming time. `busy_o` stays high for exactly `TWC_STD` cycles, or `TWC_FAST` cycles when `FAST_OPT`=1. The array is updated when `busy_o` falls.
- R7: Status read. While `busy_o`=1, a read returns a status byte. Bit 7 is the complement of bit 7 of the last accepted byte. Bit 6 is 0 on the first read of the interval and inverts after each completed read. Bits 5..0 are 0.
- R8: Output-enable inhibit. A strobe with `oe_n` held low writes nothing and does not start programming.
- R9: Glitch filter. A strobe active for fewer than `GLITCH_CYC` clock cycles is ignored.
- R10: Power-up block. After reset, or after a cycle with `por_i`=1, strobes are ignored for `POR_CYC` cycles. After that, writes work normally.
- R11: Page mismatch. During loading, a strobe whose bits 14..6 differ from the page of the first byte is not stored. It raises `page_err_o` for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| por_i | input | 1 | Power-up indication; restarts the write-block interval |
| cs_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| bus_addr | input | 15 | Byte address |
| bus_din | input | 8 | Write data |
| bus_dout | output | 8 | Read data or status byte, registered; 0 when no read is open |
| busy_o | output | 1 | High while programming runs |
| page_err_o | output | 1 | One-cycle flag for a strobe aimed at a foreign page |

## Verification
The bench loads bytes out of order and overwrites one of them. A design that wrote the whole latch, or that kept the first value, would corrupt the neighbouring bytes or show the stale data. It sends a foreign-page strobe to an offset that has already been loaded. A design that stored that byte would return the wrong value there and would also flip the status bit 7. It moves the address and the data in the middle of a strobe, to catch capture on the wrong edge. It also sends short pulses, output-enable-low strobes, strobes just after a power-up indication and strobes during programming. In each of these cases a leaky design would start programming or change the array. The status reads check the complement bit and the toggle sequence 0, 1, 0. The length of the busy interval is counted to the cycle.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  localparam int ADDR_W     = 15;
  localparam int DATA_W     = 8;
  localparam int OFS_W      = 6;
  localparam int PAGE_BYTES = 1 << OFS_W;
  localparam int PAGE_W     = ADDR_W - OFS_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } phase_e;
endpackage

// File: rtl/pgwr_strobe.sv
module pgwr_strobe
  import pgwr_pkg::*;
#(
  parameter int GLITCH_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_din,
  output logic              ld_v,
  output logic [ADDR_W-1:0] ld_addr,
  output logic [DATA_W-1:0] ld_data,
  output logic              rd_act,
  output logic              rd_end
);
  localparam int LEN_W = $clog2(GLITCH_CYC + 1);

  logic              wr_act;
  logic              wr_q, rd_q;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] din_q, din_d;

  // Combined strobes and capture selection
  always_comb begin
    wr_act = !cs_n && !we_n && oe_n;
    rd_act = !cs_n && !oe_n && we_n;
    if (!wr_act)
      len_d = '0;
    else if (len_q == LEN_W'(GLITCH_CYC))
      len_d = len_q;
    else
      len_d = len_q + 1'b1;
    addr_d = (wr_act && !wr_q) ? bus_addr : addr_q;
    din_d  = wr_act ? bus_din : din_q;
    ld_v   = wr_q && !wr_act && (len_q == LEN_W'(GLITCH_CYC));
    rd_end = rd_q && !rd_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
      len_q  <= '0;
      addr_q <= '0;
      din_q  <= '0;
    end else begin
      wr_q   <= wr_act;
      rd_q   <= rd_act;
      len_q  <= len_d;
      addr_q <= addr_d;
      din_q  <= din_d;
    end
  end

  assign ld_addr = addr_q;
  assign ld_data = din_q;
endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
  import pgwr_pkg::*;
#(
  parameter int BLC_CYC = 37500,
  parameter int TWC_CYC = 2500000,
  parameter int POR_CYC = 1250000,
  parameter int IDX_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_i,
  input  logic              ld_v,
  input  logic [PAGE_W-1:0] ld_page,
  input  logic              rd_end,
  output logic              acc,
  output logic              commit,
  output logic              busy,
  output logic              tog,
  output logic              err,
  output logic [IDX_W-1:0]  wr_page
);
  localparam int WIN_W = $clog2(BLC_CYC + 1);
  localparam int PRG_W = $clog2(TWC_CYC + 1);
  localparam int POR_W = $clog2(POR_CYC + 1);

  phase_e            ph_q, ph_d;
  logic [WIN_W-1:0]  win_q, win_d;
  logic [PRG_W-1:0]  prg_q, prg_d;
  logic [POR_W-1:0]  por_q, por_d;
  logic [PAGE_W-1:0] pg_q, pg_d;
  logic              tog_q, tog_d;
  logic              err_q, err_d;
  logic              blocked;

  always_comb begin
    blocked = (por_q != '0) || (ph_q == ST_PROG);
    acc     = ld_v && !blocked && ((ph_q == ST_IDLE) || (ld_page == pg_q));
    err_d   = ld_v && !blocked && (ph_q == ST_LOAD) && (ld_page != pg_q);
    ph_d    = ph_q;
    win_d   = win_q;
    prg_d   = prg_q;
    pg_d    = pg_q;
    tog_d   = tog_q;
    commit  = 1'b0;
    por_d   = (por_q != '0) ? por_q - 1'b1 : por_q;
    if (por_i) por_d = POR_W'(POR_CYC);
    case (ph_q)
      ST_IDLE: begin
        if (acc) begin
          ph_d  = ST_LOAD;
          pg_d  = ld_page;
          win_d = '0;
        end
      end
      ST_LOAD: begin
        if (acc) begin
          win_d = '0;
        end else if (win_q == WIN_W'(BLC_CYC - 1)) begin
          ph_d  = ST_PROG;
          prg_d = '0;
          tog_d = 1'b0;
        end else begin
          win_d = win_q + 1'b1;
        end
      end
      ST_PROG: begin
        if (rd_end) tog_d = !tog_q;
        if (prg_q == PRG_W'(TWC_CYC - 1)) begin
          commit = 1'b1;
          ph_d   = ST_IDLE;
        end else begin
          prg_d = prg_q + 1'b1;
        end
      end
      default: ph_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= ST_IDLE;
      win_q <= '0;
      prg_q <= '0;
      por_q <= POR_W'(POR_CYC);
      pg_q  <= '0;
      tog_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      win_q <= win_d;
      prg_q <= prg_d;
      por_q <= por_d;
      pg_q  <= pg_d;
      tog_q <= tog_d;
      err_q <= err_d;
    end
  end

  assign busy    = (ph_q == ST_PROG);
  assign tog     = tog_q;
  assign err     = err_q;
  assign wr_page = pg_q[IDX_W-1:0];
endmodule

// File: rtl/pgwr_latch.sv
module pgwr_latch
  import pgwr_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               acc,
  input  logic [OFS_W-1:0]                   ld_ofs,
  input  logic [DATA_W-1:0]                  ld_data,
  input  logic                               clear,
  output logic [PAGE_BYTES-1:0][DATA_W-1:0]  pg_data,
  output logic [PAGE_BYTES-1:0]              pg_mask,
  output logic                               last_msb
);
  logic last_q;

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_byte
    logic              hit;
    logic              m_q;
    logic [DATA_W-1:0] d_q;

    assign hit = acc && (ld_offs_eq(ld_ofs, i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        m_q <= 1'b0;
      else if (hit)
        m_q <= 1'b1;
      else if (clear)
        m_q <= 1'b0;
    end

    // Datapath byte: no reset, loaded under its own enable
    always_ff @(posedge clk) begin
      if (hit) d_q <= ld_data;
    end

    assign pg_mask[i] = m_q;
    assign pg_data[i] = d_q;
  end

  function automatic logic ld_offs_eq(input logic [OFS_W-1:0] o, input int k);
    return o == OFS_W'(k);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      last_q <= 1'b0;
    else if (acc)
      last_q <= ld_data[DATA_W-1];
  end

  assign last_msb = last_q;
endmodule

// File: rtl/pgwr_array.sv
module pgwr_array
  import pgwr_pkg::*;
#(
  parameter  int PAGES = 8,
  localparam int IDX_W = $clog2(PAGES)
) (
  input  logic                              clk,
  input  logic                              commit,
  input  logic [IDX_W-1:0]                  wr_page,
  input  logic [PAGE_BYTES-1:0][DATA_W-1:0] pg_data,
  input  logic [PAGE_BYTES-1:0]             pg_mask,
  input  logic [IDX_W+OFS_W-1:0]            rd_idx,
  output logic [DATA_W-1:0]                 rd_data
);
  logic [DATA_W-1:0] mem [PAGES*PAGE_BYTES];

  // Commit copies every loaded byte of the page in one cycle
  always_ff @(posedge clk) begin
    if (commit) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (pg_mask[i]) mem[{wr_page, OFS_W'(i)}] <= pg_data[i];
      end
    end
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/pgwr_eeprom.sv
module pgwr_eeprom
  import pgwr_pkg::*;
#(
  parameter int GLITCH_CYC = 4,
  parameter int BLC_CYC    = 37500,
  parameter int TWC_STD    = 2500000,
  parameter int TWC_FAST   = 750000,
  parameter int FAST_OPT   = 0,
  parameter int POR_CYC    = 1250000,
  parameter int ARR_PAGES  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_i,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_din,
  output logic [DATA_W-1:0] bus_dout,
  output logic              busy_o,
  output logic              page_err_o
);
  localparam int IDX_W   = $clog2(ARR_PAGES);
  localparam int TWC_CYC = (FAST_OPT != 0) ? TWC_FAST : TWC_STD;

  logic                              rs1_q, rs2_q, rst_sn;
  logic                              ld_v, rd_act, rd_end;
  logic [ADDR_W-1:0]                 ld_addr;
  logic [DATA_W-1:0]                 ld_data;
  logic                              acc, commit, busy, tog, err;
  logic [IDX_W-1:0]                  wr_page;
  logic [PAGE_BYTES-1:0][DATA_W-1:0] pg_data;
  logic [PAGE_BYTES-1:0]             pg_mask;
  logic                              last_msb;
  logic [DATA_W-1:0]                 rd_data;
  logic [DATA_W-1:0]                 dout_q, dout_d;

  // Reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_sn = rs2_q;

  pgwr_strobe #(.GLITCH_CYC(GLITCH_CYC)) u_strobe (
    .clk(clk), .rst_n(rst_sn), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .bus_addr(bus_addr), .bus_din(bus_din), .ld_v(ld_v), .ld_addr(ld_addr),
    .ld_data(ld_data), .rd_act(rd_act), .rd_end(rd_end)
  );

  pgwr_ctrl #(
    .BLC_CYC(BLC_CYC), .TWC_CYC(TWC_CYC), .POR_CYC(POR_CYC), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_sn), .por_i(por_i), .ld_v(ld_v),
    .ld_page(ld_addr[ADDR_W-1:OFS_W]), .rd_end(rd_end), .acc(acc),
    .commit(commit), .busy(busy), .tog(tog), .err(err), .wr_page(wr_page)
  );

  pgwr_latch u_latch (
    .clk(clk), .rst_n(rst_sn), .acc(acc), .ld_ofs(ld_addr[OFS_W-1:0]),
    .ld_data(ld_data), .clear(commit), .pg_data(pg_data), .pg_mask(pg_mask),
    .last_msb(last_msb)
  );

  pgwr_array #(.PAGES(ARR_PAGES)) u_array (
    .clk(clk), .commit(commit), .wr_page(wr_page), .pg_data(pg_data),
    .pg_mask(pg_mask), .rd_idx(bus_addr[IDX_W+OFS_W-1:0]), .rd_data(rd_data)
  );

  always_comb begin
    if (!rd_act)
      dout_d = '0;
    else if (busy)
      dout_d = {!last_msb, tog, {(DATA_W-2){1'b0}}};
    else
      dout_d = rd_data;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)
      dout_q <= '0;
    else
      dout_q <= dout_d;
  end

  assign bus_dout   = dout_q;
  assign busy_o     = busy;
  assign page_err_o = err;
endmodule

// File: rtl/pgwr_checker.sv
module pgwr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       oe_n,
  input logic       we_n,
  input logic       busy_o,
  input logic       page_err_o,
  input logic [7:0] bus_dout
);
  a_r11_err_single: assert property (@(posedge clk) disable iff (!rst_n)
    page_err_o |=> !page_err_o);

  a_r2_dout_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || oe_n || !we_n) |=> (bus_dout == 8'h00));

  a_r7_status_low: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !cs_n && !oe_n && we_n) |=> (bus_dout[5:0] == 6'd0));

  a_r6_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |=> busy_o);
endmodule

bind pgwr_eeprom pgwr_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
  .busy_o(busy_o), .page_err_o(page_err_o), .bus_dout(bus_dout)
);

// File: tb/sim_pgwr_eeprom.sv
module sim_pgwr_eeprom;
  localparam int TWC = 300;
  localparam int BLC = 40;
  localparam int POR = 50;

  logic        clk = 1'b0;
  logic        rst_n, por_i, cs_n, oe_n, we_n;
  logic [14:0] bus_addr;
  logic [7:0]  bus_din, bus_dout;
  logic        busy_o, page_err_o;

  int nchk = 0, nerr = 0;
  int bcnt = 0, blen = 0, ecnt = 0;
  bit bseen = 0, smp = 0, done = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  pgwr_eeprom #(
    .GLITCH_CYC(4), .BLC_CYC(BLC), .TWC_STD(TWC), .TWC_FAST(100),
    .FAST_OPT(0), .POR_CYC(POR), .ARR_PAGES(8)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .por_i(por_i), .cs_n(cs_n), .oe_n(oe_n),
    .we_n(we_n), .bus_addr(bus_addr), .bus_din(bus_din), .bus_dout(bus_dout),
    .busy_o(busy_o), .page_err_o(page_err_o)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'(8'h11 + 3 * i);
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // Monitor: scoreboard pops and busy/error bookkeeping
  always @(negedge clk) begin
    if (smp) begin
      logic [7:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(32'(bus_dout), 32'(e), t);
      smp = 0;
    end
    if (busy_o) begin
      bcnt++;
      bseen = 1;
    end else if (bcnt != 0) begin
      blen = bcnt;
      bcnt = 0;
    end
    if (page_err_o) ecnt++;
  end

  task automatic wr_byte(input logic [14:0] a, input logic [7:0] d,
                         input int hold, input bit oe_low);
    @(posedge clk); #1;
    bus_addr = a; bus_din = d; oe_n = !oe_low; cs_n = 1'b0; we_n = 1'b0;
    repeat (hold) @(posedge clk);
    #1; we_n = 1'b1; cs_n = 1'b1; oe_n = 1'b1;
    repeat (2) @(posedge clk);
  endtask

  task automatic wr_split(input logic [14:0] a1, input logic [7:0] d1,
                          input logic [14:0] a2, input logic [7:0] d2);
    @(posedge clk); #1;
    bus_addr = a1; bus_din = d1; cs_n = 1'b0; we_n = 1'b0;
    repeat (3) @(posedge clk);
    #1; bus_addr = a2; bus_din = d2;
    repeat (3) @(posedge clk);
    #1; we_n = 1'b1; cs_n = 1'b1;
    repeat (2) @(posedge clk);
  endtask

  task automatic rd_byte(input logic [14:0] a, input logic [7:0] e, input string tag);
    @(posedge clk); #1;
    bus_addr = a; cs_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    smp = 1;
    wait (smp == 0);
    @(posedge clk); #1;
    cs_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wait_prog();
    wait (busy_o == 1'b1);
    wait (busy_o == 1'b0);
    repeat (2) @(posedge clk);
  endtask

  initial begin
    int e0;
    rst_n = 1'b0; por_i = 1'b0; cs_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    bus_addr = '0; bus_din = '0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(32'(busy_o), 0, "R1 busy in reset");
    chk(32'(page_err_o), 0, "R1 err in reset");
    chk(32'(bus_dout), 0, "R1 dout in reset");
    rst_n = 1'b1;
    repeat (POR + 10) @(posedge clk);
    chk(32'(bus_dout), 0, "R1 dout after reset");

    // R4: full page fill, bytes well inside the load window
    for (int i = 0; i < 64; i++) wr_byte(15'h0040 + 15'(i), pat(i), 6, 1'b0);
    wait_prog();
    chk(32'(blen), 32'(TWC), "R6 busy length");
    rd_byte(15'h0040, pat(0), "R4 fill first");
    rd_byte(15'h007F, pat(63), "R4 fill last");
    rd_byte(15'h0060, pat(32), "R2 read");

    // R2: deselected read leaves the output at 0
    @(posedge clk); #1; bus_addr = 15'h0040; cs_n = 1'b1; oe_n = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(32'(bus_dout), 0, "R2 deselected");
    @(posedge clk); #1; oe_n = 1'b1;

    // R4/R11: out of order, overwrite, foreign page onto a used offset
    e0 = ecnt;
    wr_byte(15'h0045, 8'h5A, 6, 1'b0);
    wr_byte(15'h0042, 8'hC3, 6, 1'b0);
    wr_byte(15'h0045, 8'h77, 6, 1'b0);
    wr_byte(15'h0085, 8'h99, 6, 1'b0);
    @(negedge clk);
    chk(32'(ecnt - e0), 1, "R11 error pulse");
    wait (busy_o == 1'b1);
    wr_byte(15'h0043, 8'hEE, 6, 1'b0);
    rd_byte(15'h0045, 8'h80, "R7 status first");
    rd_byte(15'h0045, 8'hC0, "R7 status second");
    rd_byte(15'h0045, 8'h80, "R7 status third");
    wait (busy_o == 1'b0);
    repeat (2) @(posedge clk);
    rd_byte(15'h0045, 8'h77, "R11 foreign byte dropped");
    rd_byte(15'h0042, 8'hC3, "R4 reordered byte");
    rd_byte(15'h0043, pat(3), "R5 write during busy ignored");
    rd_byte(15'h0044, pat(4), "R4 unloaded byte kept");

    // R3: address from strobe start, data from strobe end
    wr_split(15'h0050, 8'h12, 15'h0051, 8'h3C);
    wait_prog();
    rd_byte(15'h0050, 8'h3C, "R3 capture");
    rd_byte(15'h0051, pat(17), "R3 moved address untouched");

    // R9: short pulse
    bseen = 0;
    wr_byte(15'h0060, 8'h00, 2, 1'b0);
    repeat (BLC + 20) @(posedge clk);
    chk(32'(bseen), 0, "R9 glitch no programming");
    rd_byte(15'h0060, pat(32), "R9 glitch no write");

    // R8: output enable low during strobe
    bseen = 0;
    wr_byte(15'h0061, 8'h00, 6, 1'b1);
    repeat (BLC + 20) @(posedge clk);
    chk(32'(bseen), 0, "R8 inhibit no programming");
    rd_byte(15'h0061, pat(33), "R8 inhibit no write");

    // R10: power-up block
    @(posedge clk); #1; por_i = 1'b1;
    @(posedge clk); #1; por_i = 1'b0;
    bseen = 0;
    wr_byte(15'h0062, 8'h00, 6, 1'b0);
    repeat (POR + 10) @(posedge clk);
    chk(32'(bseen), 0, "R10 blocked no programming");
    rd_byte(15'h0062, pat(34), "R10 blocked no write");
    wr_byte(15'h0062, 8'h5B, 6, 1'b0);
    wait_prog();
    rd_byte(15'h0062, 8'h5B, "R10 released write");

    // R5: window expiry then strobe while busy
    wr_byte(15'h0063, 8'h01, 6, 1'b0);
    repeat (BLC + 5) @(posedge clk);
    @(negedge clk);
    chk(32'(busy_o), 1, "R5 window expired");
    wr_byte(15'h0064, 8'h02, 6, 1'b0);
    wait (busy_o == 1'b0);
    repeat (2) @(posedge clk);
    chk(32'(blen), 32'(TWC), "R6 busy length again");
    rd_byte(15'h0063, 8'h01, "R5 committed byte");
    rd_byte(15'h0064, pat(36), "R5 late byte ignored");

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule